// File: doc/BRIEF.md
# SPI Master with Slave-Ready Gating

This block drives a single-chip-select SPI bus and adds a fifth, active-low ready line driven by the slave. Words of 8 bits arrive on a valid/ready command port. Each word carries a flag that says whether it closes the frame. Chip select falls when the first word is accepted. The master shifts each word out MSB first while it collects the word coming back from the slave. It returns that word as a one-cycle response strobe. When the last word of a frame has finished, chip select goes high again.

Clock polarity and phase are programmable, so all four SPI modes are available. A divider sets the SCLK half period. Separate idle counts set three waits: the time after chip select falls and before the first edge, the pause between words, and the hold after the last edge. Before each word, the master checks the synchronized ready line. If gating is enabled, SCLK stays at its idle level until the slave signals ready. A programmable limit ends a wait that runs too long. It raises an error strobe and releases chip select.

Top module: `spi_ready_master`

## Requirements
- R1: After reset, csN is 1, sclk equals cfgCpol, cmdReady is 1, and rspValid and errFlag are 0.
- R2: A command accepted while idle (cmdValid and cmdReady both 1) pulls csN low. Every word goes out on mosi MSB first, as eight bits per word.
- R3: Whenever csN is high, sclk sits at the level of cfgCpol.
- R4: With cfgCpha=0, the master samples miso on the odd-numbered SCLK edges of a word (1, 3, …, 15) and changes mosi on the even ones. With cfgCpha=1, it changes mosi on odd edges from edge 3 and samples miso on even edges. Mode 3 (cfgCpol=1, cfgCpha=1) therefore samples on rising edges and shifts on falling edges.
- R5: A word has exactly 16 SCLK edges. Consecutive edges within a word are cfgDiv+1 system clocks apart.
- R6: For the first word of a frame, when ready is already asserted, csN is low for cfgLeadGap+cfgDiv+3 clock cycles before the first SCLK edge.
- R7: After the last edge of a word sent with cmdLast=1, csN stays low for cfgTrailGap more cycles and then goes high.
- R8: A word sent with cmdLast=0 keeps csN low. cmdReady stays high until the next word arrives. When that word is already waiting, cfgWordGap+cfgDiv+3 idle cycles pass between the last edge of one word and the first edge of the next.
- R9: With cfgGateEn=1, no word begins while slvRdyN, after its two-flop synchronizer, is high. SCLK stays at its idle level throughout the stall.
- R10: With cfgGateEn=0, slvRdyN is ignored and words run at once.
- R11: If ready stays deasserted for cfgTimeout+1 cycles while the master is waiting, errFlag pulses for one cycle. csN goes high on that same cycle, and no response is produced for the word. For a first word, csN has then been low for cfgLeadGap+cfgTimeout+2 cycles.
- R12: For each completed word, rspValid pulses for one cycle, and rspData holds the received byte in the order received, MSB first. rspValid and errFlag are never high together.
- R13: SCLK changes only while csN is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgCpol | input | 1 | SCLK idle level |
| cfgCpha | input | 1 | Sampling phase: 0 samples on leading edges, 1 samples on trailing edges |
| cfgDiv | input | 8 | SCLK half period minus one, in clock cycles |
| cfgLeadGap | input | 8 | Idle count after csN falls |
| cfgWordGap | input | 8 | Idle count between words |
| cfgTrailGap | input | 8 | Idle count after the last edge |
| cfgTimeout | input | 16 | Ready-wait limit minus one, in clock cycles |
| cfgGateEn | input | 1 | Enable ready gating |
| cmdValid | input | 1 | Command word valid |
| cmdReady | output | 1 | Command word accepted |
| cmdData | input | 8 | Word to transmit |
| cmdLast | input | 1 | Release chip select after this word |
| rspValid | output | 1 | Received word strobe |
| rspData | output | 8 | Received word |
| errFlag | output | 1 | Ready-wait timeout strobe |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 1 | Active-low chip select |
| slvRdyN | input | 1 | Active-low slave ready |

## Verification
Two situations are hard to reach from the ports. One is a stall placed exactly between two words of one frame. The other is a wait that runs out in the middle of a frame setup. The bench watches for the response strobe of the first word and raises the ready line in that same cycle. It sets the word gap larger than the synchronizer delay, so the stall is seen at the decision point. It then holds ready high for a known stretch and measures the quiet time at the pins. For the timeout, ready is held high from before the command arrives. The bench counts the cycles csN spends low and checks that no response or slave-side word appears.

// File: rtl/spi_ready_pkg.sv
package spi_ready_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_WAIT,
    ST_SHIFT,
    ST_HOLD,
    ST_GAP,
    ST_TRAIL
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTx;     // latch a new command word
    logic startWord;  // clear edge and divider counters
    logic shiftEn;    // word in progress
  } dpStrobe_t;

endpackage

// File: rtl/spi_ready_dp.sv
module spi_ready_dp
  import spi_ready_pkg::*;
#(
  parameter int DW   = 8,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgCpha,
  input  logic [DIVW-1:0] cfgDiv,
  input  dpStrobe_t       strb,
  input  logic [DW-1:0]   cmdData,
  input  logic            miso,
  output logic            sclkRaw,
  output logic            mosi,
  output logic            wordDone,
  output logic            rspValid,
  output logic [DW-1:0]   rspData
);

  localparam int EDGES = 2 * DW;
  localparam int EW    = $clog2(EDGES + 1);

  logic [DIVW-1:0] divCnt;
  logic [EW-1:0]   edgeCnt;
  logic [EW-1:0]   nextEdge;
  logic [DW-1:0]   txSh;
  logic [DW-1:0]   rxSh;
  logic            edgeNow;
  logic            sampleNow;
  logic            shiftNow;

  assign edgeNow   = strb.shiftEn && (divCnt == '0);
  assign nextEdge  = edgeCnt + EW'(1);
  assign sampleNow = edgeNow && (nextEdge[0] ^ cfgCpha);
  assign shiftNow  = edgeNow && !(nextEdge[0] ^ cfgCpha) && (nextEdge >= EW'(2));
  assign wordDone  = edgeNow && (nextEdge == EW'(EDGES));
  assign mosi      = txSh[DW-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      edgeCnt <= '0;
      sclkRaw <= 1'b0;
    end else if (strb.startWord) begin
      divCnt  <= cfgDiv;
      edgeCnt <= '0;
      sclkRaw <= 1'b0;
    end else if (strb.shiftEn) begin
      if (divCnt == '0) begin
        divCnt  <= cfgDiv;
        edgeCnt <= nextEdge;
        sclkRaw <= ~sclkRaw;
      end else begin
        divCnt <= divCnt - DIVW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh     <= '0;
      rxSh     <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strb.loadTx)  txSh <= cmdData;
      else if (shiftNow) txSh <= {txSh[DW-2:0], 1'b0};
      if (sampleNow) rxSh <= {rxSh[DW-2:0], miso};
      rspValid <= wordDone;
      if (wordDone) rspData <= sampleNow ? {rxSh[DW-2:0], miso} : rxSh;
    end
  end

  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt <= EW'(EDGES)) else $error("edge count overrun"); // R5

endmodule

// File: rtl/spi_ready_ctrl.sv
module spi_ready_ctrl
  import spi_ready_pkg::*;
#(
  parameter int GW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgGateEn,
  input  logic [GW-1:0] cfgLeadGap,
  input  logic [GW-1:0] cfgWordGap,
  input  logic [GW-1:0] cfgTrailGap,
  input  logic [TW-1:0] cfgTimeout,
  input  logic          cmdValid,
  input  logic          cmdLast,
  input  logic          slvRdyN,
  input  logic          wordDone,
  output logic          cmdReady,
  output logic          csN,
  output logic          errFlag,
  output dpStrobe_t     strb
);

  ctrlState_e    state;
  logic [GW-1:0] gapCnt;
  logic [TW-1:0] waitCnt;
  logic [1:0]    rdySync;
  logic          rdyOk;
  logic          lastWord;
  logic          goNow;

  assign rdyOk    = ~rdySync[1];
  assign goNow    = !cfgGateEn || rdyOk;
  assign cmdReady = (state == ST_IDLE) || (state == ST_HOLD);
  assign csN      = (state == ST_IDLE);

  always_comb begin
    strb.loadTx    = cmdValid && cmdReady;
    strb.startWord = (state == ST_WAIT) && goNow;
    strb.shiftEn   = (state == ST_SHIFT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdySync <= 2'b11;
    else       rdySync <= {rdySync[0], slvRdyN};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      gapCnt   <= '0;
      waitCnt  <= '0;
      lastWord <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      errFlag <= 1'b0;
      case (state)
        ST_IDLE: if (cmdValid) begin
          state    <= ST_LEAD;
          gapCnt   <= cfgLeadGap;
          lastWord <= cmdLast;
        end
        ST_LEAD, ST_GAP: begin
          if (gapCnt == '0) begin
            state   <= ST_WAIT;
            waitCnt <= '0;
          end else gapCnt <= gapCnt - GW'(1);
        end
        ST_WAIT: begin
          if (goNow) state <= ST_SHIFT;
          else if (waitCnt == cfgTimeout) begin
            state   <= ST_IDLE;
            errFlag <= 1'b1;
          end else waitCnt <= waitCnt + TW'(1);
        end
        ST_SHIFT: if (wordDone) begin
          if (lastWord) begin
            state  <= ST_TRAIL;
            gapCnt <= cfgTrailGap;
          end else state <= ST_HOLD;
        end
        ST_HOLD: if (cmdValid) begin
          state    <= ST_GAP;
          gapCnt   <= cfgWordGap;
          lastWord <= cmdLast;
        end
        ST_TRAIL: begin
          if (gapCnt == '0) state <= ST_IDLE;
          else gapCnt <= gapCnt - GW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ERR_FROM_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> ($past(state) == ST_WAIT)) else $error("error outside wait"); // R11
  AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && cfgGateEn && !rdyOk) |=> (state != ST_SHIFT)) else $error("word began unready"); // R9
  AST_SHIFT_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT && !wordDone) |=> (state == ST_SHIFT)) else $error("word cut short"); // R5

endmodule

// File: rtl/spi_ready_master.sv
module spi_ready_master
  import spi_ready_pkg::*;
#(
  parameter int DW   = 8,
  parameter int DIVW = 8,
  parameter int GW   = 8,
  parameter int TW   = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgCpol,
  input  logic            cfgCpha,
  input  logic [DIVW-1:0] cfgDiv,
  input  logic [GW-1:0]   cfgLeadGap,
  input  logic [GW-1:0]   cfgWordGap,
  input  logic [GW-1:0]   cfgTrailGap,
  input  logic [TW-1:0]   cfgTimeout,
  input  logic            cfgGateEn,
  input  logic            cmdValid,
  output logic            cmdReady,
  input  logic [DW-1:0]   cmdData,
  input  logic            cmdLast,
  output logic            rspValid,
  output logic [DW-1:0]   rspData,
  output logic            errFlag,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic            csN,
  input  logic            slvRdyN
);

  dpStrobe_t strb;
  logic      sclkRaw;
  logic      wordDone;

  spi_ready_ctrl #(.GW(GW), .TW(TW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgGateEn(cfgGateEn),
    .cfgLeadGap(cfgLeadGap), .cfgWordGap(cfgWordGap), .cfgTrailGap(cfgTrailGap),
    .cfgTimeout(cfgTimeout), .cmdValid(cmdValid), .cmdLast(cmdLast),
    .slvRdyN(slvRdyN), .wordDone(wordDone), .cmdReady(cmdReady),
    .csN(csN), .errFlag(errFlag), .strb(strb)
  );

  spi_ready_dp #(.DW(DW), .DIVW(DIVW)) u_dp (
    .clk(clk), .rstN(rstN), .cfgCpha(cfgCpha), .cfgDiv(cfgDiv),
    .strb(strb), .cmdData(cmdData), .miso(miso), .sclkRaw(sclkRaw),
    .mosi(mosi), .wordDone(wordDone), .rspValid(rspValid), .rspData(rspData)
  );

  assign sclk = sclkRaw ^ cfgCpol;

  AST_CS_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (sclk == cfgCpol)) else $error("sclk off idle level"); // R3
  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclkRaw) |-> (!csN && !$past(csN))) else $error("sclk moved unselected"); // R13
  AST_RSP_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rspValid && errFlag)) else $error("response and error together"); // R12

endmodule

// File: tb/spi_ready_master_tb.sv
module spi_ready_master_tb;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgCpol = 1'b0, cfgCpha = 1'b0, cfgGateEn = 1'b1;
  logic [7:0] cfgDiv = 8'd1, cfgLeadGap = 8'd2, cfgWordGap = 8'd2, cfgTrailGap = 8'd1;
  logic [15:0] cfgTimeout = 16'd500;
  logic cmdValid = 1'b0, cmdLast = 1'b0;
  logic [7:0] cmdData = 8'h00;
  logic cmdReady, rspValid, errFlag, sclk, mosi, csN;
  logic [7:0] rspData;
  logic miso = 1'b0;
  logic slvRdyN = 1'b0;

  int nChk = 0, nFail = 0;
  logic [7:0] expMosi[$], expRsp[$], replyQ[$];
  int firstQuiet, gapQuiet, riseQuiet, frameWords, errSeen = 0, rspSeen = 0;
  int quiet = 0, e = 0, wordsInFrame = 0, rdyHigh = 0;
  logic prevS = 1'b0, prevCs = 1'b1, armed = 1'b0;
  logic [7:0] curWord = 8'h00, rxW = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_ready_master u_dut (
    .clk(clk), .rstN(rstN), .cfgCpol(cfgCpol), .cfgCpha(cfgCpha), .cfgDiv(cfgDiv),
    .cfgLeadGap(cfgLeadGap), .cfgWordGap(cfgWordGap), .cfgTrailGap(cfgTrailGap),
    .cfgTimeout(cfgTimeout), .cfgGateEn(cfgGateEn), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdData(cmdData), .cmdLast(cmdLast), .rspValid(rspValid),
    .rspData(rspData), .errFlag(errFlag), .sclk(sclk), .mosi(mosi), .miso(miso),
    .csN(csN), .slvRdyN(slvRdyN)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural slave and per-clock pin model
  always @(negedge clk) begin
    if (!rstN) begin
      prevS = sclk; prevCs = 1'b1; e = 0; quiet = 0; armed = 1'b0;
    end else begin
      if (csN) chk(sclk === cfgCpol, "R3 idle level", int'(sclk), int'(cfgCpol));
      chk(!(rspValid && errFlag), "R12 rsp/err exclusive", int'(errFlag), 0);
      if (slvRdyN) rdyHigh++; else rdyHigh = 0;
      if (!csN) begin
        if (prevCs) begin quiet = 0; wordsInFrame = 0; e = 0; end
        if (!armed) begin
          curWord = (replyQ.size() > 0) ? replyQ.pop_front() : 8'h00;
          armed = 1'b1;
        end
        if (sclk !== prevS) begin
          e++;
          if (e == 1) begin
            if (wordsInFrame == 0) firstQuiet = quiet; else gapQuiet = quiet;
            if (cfgGateEn)
              chk(rdyHigh < int'(cfgDiv) + 6, "R9 word began while unready", rdyHigh, 0);
          end else begin
            chk(quiet == int'(cfgDiv), "R5 half period", quiet + 1, int'(cfgDiv) + 1);
          end
          if (((e % 2) == 1) ^ cfgCpha) rxW = {rxW[6:0], mosi};
          if (e == 16) begin
            if (expMosi.size() > 0) begin
              logic [7:0] em;
              em = expMosi.pop_front();
              chk(rxW == em, "R2 mosi word", int'(rxW), int'(em));
            end else chk(1'b0, "R2 unexpected word", int'(rxW), -1);
            wordsInFrame++;
            e = 0;
            curWord = (replyQ.size() > 0) ? replyQ.pop_front() : 8'h00;
          end
          quiet = 0;
        end else quiet++;
        begin
          int idx;
          idx = cfgCpha ? ((e == 0) ? 0 : (e - 1) / 2) : e / 2;
          if (idx > 7) idx = 7;
          miso = curWord[7 - idx];
        end
      end else begin
        if (!prevCs) begin riseQuiet = quiet; frameWords = wordsInFrame; end
        e = 0; armed = 1'b0;
      end
      prevS = sclk; prevCs = csN;
    end
  end

  // response scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (rspValid) begin
        rspSeen++;
        if (expRsp.size() > 0) begin
          logic [7:0] er;
          er = expRsp.pop_front();
          chk(rspData == er, "R4 received word", int'(rspData), int'(er));
        end else chk(1'b0, "R12 unexpected response", int'(rspData), -1);
      end
      if (errFlag) errSeen++;
    end
  end

  task automatic setCfg(input logic cp, input logic ch, input int dv, input int ld,
                        input int wg, input int tr, input int to, input logic ge);
    cfgCpol = cp; cfgCpha = ch; cfgDiv = 8'(dv); cfgLeadGap = 8'(ld);
    cfgWordGap = 8'(wg); cfgTrailGap = 8'(tr); cfgTimeout = 16'(to); cfgGateEn = ge;
    @(negedge clk);
  endtask

  task automatic sendWord(input logic [7:0] d, input logic last);
    cmdData = d; cmdLast = last; cmdValid = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] d, input logic [7:0] rep, input logic last);
    expMosi.push_back(d); replyQ.push_back(rep); expRsp.push_back(rep);
    sendWord(d, last);
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (!(csN && cmdReady));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    int errBase, rspBase;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(csN == 1'b1, "R1 csN", int'(csN), 1);
    chk(sclk == cfgCpol, "R1 sclk", int'(sclk), int'(cfgCpol));
    chk(cmdReady == 1'b1, "R1 cmdReady", int'(cmdReady), 1);
    chk(!rspValid && !errFlag, "R1 strobes", int'(rspValid) + int'(errFlag), 0);

    // all four modes, R2 R4 R5 R6 R7
    for (int m = 0; m < 4; m++) begin
      int dv, ld, tr;
      dv = (m == 0) ? 0 : (m == 1) ? 1 : (m == 2) ? 3 : 2;
      ld = m + 1; tr = 3 - m;
      setCfg(m[1], m[0], dv, ld, 2, tr, 500, 1'b1);
      xfer(8'hA5 ^ 8'(m * 37), 8'h3C + 8'(m * 19), 1'b1);
      waitIdle();
      chk(firstQuiet == ld + dv + 3, "R6 lead time", firstQuiet, ld + dv + 3);
      chk(riseQuiet == tr, "R7 trail time", riseQuiet, tr);
      chk(frameWords == 1, "R2 one word", frameWords, 1);
    end

    // burst of three words under one chip select, R8
    setCfg(1'b0, 1'b0, 1, 1, 4, 1, 500, 1'b1);
    xfer(8'h81, 8'h7E, 1'b0);
    xfer(8'h00, 8'hFF, 1'b0);
    xfer(8'hFF, 8'h01, 1'b1);
    waitIdle();
    chk(frameWords == 3, "R8 words per frame", frameWords, 3);
    chk(gapQuiet == 4 + 1 + 3, "R8 word gap", gapQuiet, 8);

    // stall between words, R9
    setCfg(1'b1, 1'b1, 1, 1, 4, 1, 1000, 1'b1);
    errBase = errSeen;
    xfer(8'h5A, 8'hC3, 1'b0);
    fork
      begin
        while (!rspValid) @(negedge clk);
        slvRdyN = 1'b1;
        repeat (40) @(negedge clk);
        slvRdyN = 1'b0;
      end
      xfer(8'h96, 8'h69, 1'b1);
    join
    waitIdle();
    chk(gapQuiet >= 40, "R9 stall between words", gapQuiet, 40);
    chk(frameWords == 2 && errSeen == errBase, "R9 stalled frame completes", frameWords, 2);

    // stall before the first word, R9
    setCfg(1'b0, 1'b1, 2, 2, 2, 2, 200, 1'b1);
    slvRdyN = 1'b1;
    fork
      xfer(8'h3E, 8'hE3, 1'b1);
      begin repeat (30) @(negedge clk); slvRdyN = 1'b0; end
    join
    waitIdle();
    chk(firstQuiet >= 30, "R9 stall before first word", firstQuiet, 30);
    chk(errSeen == errBase, "R9 no timeout", errSeen - errBase, 0);

    // gating off ignores ready, R10
    setCfg(1'b0, 1'b0, 1, 2, 2, 1, 5, 1'b0);
    slvRdyN = 1'b1;
    xfer(8'hC7, 8'h1D, 1'b1);
    waitIdle();
    chk(frameWords == 1, "R10 word runs unready", frameWords, 1);
    chk(firstQuiet == 2 + 1 + 3, "R10 no wait added", firstQuiet, 6);
    chk(errSeen == errBase, "R10 no error", errSeen - errBase, 0);

    // timeout aborts, R11
    setCfg(1'b0, 1'b0, 1, 3, 2, 1, 20, 1'b1);
    rspBase = rspSeen;
    sendWord(8'hEE, 1'b1);
    waitIdle();
    slvRdyN = 1'b0;
    chk(errSeen == errBase + 1, "R11 one error strobe", errSeen - errBase, 1);
    chk(riseQuiet == 3 + 20 + 2, "R11 cs low time", riseQuiet, 25);
    chk(frameWords == 0, "R11 no word shifted", frameWords, 0);
    chk(rspSeen == rspBase, "R11 no response", rspSeen - rspBase, 0);
    chk(cmdReady == 1'b1, "R11 ready after abort", int'(cmdReady), 1);

    // recovery after abort, R12
    setCfg(1'b0, 1'b0, 0, 0, 0, 0, 20, 1'b1);
    rspBase = rspSeen;
    xfer(8'h42, 8'hBD, 1'b1);
    waitIdle();
    chk(rspSeen == rspBase + 1, "R12 one response per word", rspSeen - rspBase, 1);
    chk(expRsp.size() == 0 && expMosi.size() == 0, "R12 queues drained",
        expRsp.size() + expMosi.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule